// File: doc/BRIEF.md
# Port-Indexed MDIO Access Engine

This block lets software reach Ethernet PHY management registers by naming a switch port instead of a bus and a PHY address. Software fills two lookup tables once: one gives every port its 5-bit PHY address, the other gives every port one of four MDIO buses. A global select register fixes each bus in Clause 22 or Clause 45 mode. To run an access, software loads the data, MMD-address and write-mask registers, then writes a command word with its start bit set.

The engine latches the command and resolves the port to a bus and a PHY address. It checks that the request is legal, then serialises one frame (Clause 22) or an address frame followed by a data frame (Clause 45) on the chosen bus. A read leaves the returned 16 bits in the low half of the data register. The start bit reads as one for the whole access and clears by itself at the end. A separate failure flag reports a request that was refused.

MDC is made from the system clock: it stays low for `DIV_HALF` clocks and high for `DIV_HALF` clocks per bit. The master changes MDIO during the low phase, samples it at the end of the first high clock, and releases the line for turnaround and read data.

Top module: `mdix_engine`

## Requirements
- R1: Register word addresses are: command 0, data 1, MMD 2, write mask 3, global select 4, PHY-address table 5 to 9, bus table 10 to 11. After reset every register reads zero, and every MDC and MDIO output enable is low.
- R2: Command bit 0 (start) reads one from acceptance until completion and then clears by itself. Bits 24:1 read back as written. A command write made while the start bit is one is ignored entirely.
- R3: A Clause 22 write (command bit 1 = 0, bit 2 = 1) sends 32 ones, then 01, 01, PHY address, register number (command bits 24:20), 10, and data bits 31:16, all driven, MSB first.
- R4: A Clause 22 read (bit 2 = 0) targets the port in data bits 31:16 and sends 32 ones, 01, 10, PHY address and register number. The master then releases MDIO for 2 turnaround bits and 16 data bits. The sampled data lands in data bits 15:0, and data bits 31:16 keep their value.
- R5: A Clause 45 access (bit 1 = 1) sends an address frame 00, 00, PHY, device (MMD bits 20:16), 10, MMD bits 15:0. It then sends a frame 00, opcode 01 (write) or 11 (read), PHY, device, with write data or a released read as in R3/R4.
- R6: Port i uses the PHY address at bits (i mod 6)*5 of table word i/6 and the bus at bits (i mod 16)*2 of bus word i/16. Tables read back as written, and only the selected bus shows MDC or output-enable activity.
- R7: A write whose mask (bit N = port N) has zero bits set, more than one bit set, or its bit at N >= 28 completes with failure flag bit 25 set, and no bus toggles.
- R8: A command whose type bit differs from global-select bit 16+bus for the resolved bus completes with the failure flag set and no bus activity.
- R9: The failure flag clears when a new command is accepted, so it reads zero after a successful access.
- R10: MDC stays high for exactly DIV_HALF clocks per bit and MDIO never changes while MDC is high.
- R11: A read naming a port number of 28 or more completes with the failure flag set and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | NBUS | Management clock, one per bus |
| mdio_o | output | NBUS | MDIO output value per bus |
| mdio_oe | output | NBUS | MDIO output enable per bus |
| mdio_i | input | NBUS | MDIO input value per bus |

## Verification
The checks on bus exclusivity and MDC shape assume that software writes only one command at a time and loads the lookup tables before starting accesses. They also assume that a PHY drives mdio_i only while the output enable is low. The stimulus loads the tables once after reset and polls the start bit until it clears before it issues the next command. Its bus models drive read data only in the released bit slots of the final frame. Random accesses choose the frame type from the mode of the port's bus, and directed cases deliberately break the mask, port range and type rules.

// File: rtl/mdix_pkg.sv
package mdix_pkg;

    localparam int REG_AW     = 4;
    localparam int A_CMD      = 0;
    localparam int A_DATA     = 1;
    localparam int A_MMD      = 2;
    localparam int A_WMASK    = 3;
    localparam int A_GSEL     = 4;
    localparam int A_PHYTAB   = 5;
    localparam int GSEL_LSB   = 16;
    localparam int PORT_IDX_W = 5;

    // bit slots within one 64-bit serial frame
    localparam int PRE_BITS    = 32;
    localparam int RD_OWN_BITS = 46;
    localparam int RD_DAT_POS  = 48;
    localparam int LAST_POS    = 63;

    localparam logic [1:0] ST_C22  = 2'b01;
    localparam logic [1:0] ST_C45  = 2'b00;
    localparam logic [1:0] OP_ADDR = 2'b00;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] OP_RD22 = 2'b10;
    localparam logic [1:0] OP_RD45 = 2'b11;

    typedef enum logic [1:0] {SQ_IDLE, SQ_RESOLVE, SQ_ADDR, SQ_DATA} seq_e;

    // command bits 24:1, in the order their positions require
    typedef struct packed {
        logic [4:0]  regnum;
        logic [4:0]  park;
        logic [11:0] main;
        logic        wr;
        logic        c45;
    } cmd_t;

    function automatic logic [31:0] pack_frame(input logic [1:0] st, input logic [1:0] op,
                                               input logic [4:0] phy, input logic [4:0] sub,
                                               input logic [15:0] payload);
        return {st, op, phy, sub, 2'b10, payload};
    endfunction

    function automatic int popcount32(input logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [PORT_IDX_W-1:0] low_index(input logic [31:0] v);
        logic [PORT_IDX_W-1:0] r = '0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = PORT_IDX_W'(i);
        return r;
    endfunction

endpackage

// File: rtl/mdix_frame.sv
module mdix_frame
    import mdix_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] frame,
    input  logic        drive_all,
    input  logic        mdi,
    output logic        active,
    output logic        mdc_lvl,
    output logic        mdo,
    output logic        mdoe,
    output logic [15:0] rdata,
    output logic        done
);
    localparam int PER = 2 * DIV_HALF;
    localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

    logic [CW-1:0] cnt;
    logic [5:0]    idx;
    logic [31:0]   frm;
    logic          drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
            frm    <= '0;
            drv    <= 1'b0;
            rdata  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    idx    <= '0;
                    frm    <= frame;
                    drv    <= drive_all;
                end
            end else begin
                if (cnt == CW'(DIV_HALF) && int'(idx) >= RD_DAT_POS)
                    rdata <= {rdata[14:0], mdi};
                if (cnt == CW'(PER - 1)) begin
                    cnt <= '0;
                    if (int'(idx) == LAST_POS) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        idx <= idx + 6'd1;
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign mdc_lvl = active && (cnt >= CW'(DIV_HALF));
    assign mdo     = active && (idx[5] ? frm[5'd31 - idx[4:0]] : 1'b1);
    assign mdoe    = active && (drv || int'(idx) < RD_OWN_BITS);

endmodule

// File: rtl/mdix_busmux.sv
module mdix_busmux #(
    parameter int NBUS = 4,
    localparam int BW  = (NBUS > 2) ? $clog2(NBUS) : 1
) (
    input  logic [BW-1:0]   sel,
    input  logic            mdc_lvl,
    input  logic            mdo,
    input  logic            mdoe,
    input  logic [NBUS-1:0] mdio_i,
    output logic [NBUS-1:0] mdc,
    output logic [NBUS-1:0] mdio_o,
    output logic [NBUS-1:0] mdio_oe,
    output logic            mdi
);
    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        logic hit;
        assign hit        = (int'(sel) == b);
        assign mdc[b]     = hit && mdc_lvl;
        assign mdio_o[b]  = hit && mdo;
        assign mdio_oe[b] = hit && mdoe;
    end

    assign mdi = mdio_i[sel];

endmodule

// File: rtl/mdix_portmap.sv
module mdix_portmap
    import mdix_pkg::*;
#(
    parameter int NPORTS = 28,
    parameter int NBUS   = 4,
    localparam int BW    = (NBUS > 2) ? $clog2(NBUS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [REG_AW-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic [PORT_IDX_W-1:0] port,
    output logic [4:0]            phy,
    output logic [BW-1:0]         bus,
    output logic [31:0]           rd_data
);
    localparam int PA_WORDS = (NPORTS + 5) / 6;
    localparam int BS_BASE  = A_PHYTAB + PA_WORDS;

    logic [4:0]    phy_tab [NPORTS];
    logic [BW-1:0] bus_tab [NPORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPORTS; i++) begin
                phy_tab[i] <= '0;
                bus_tab[i] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < NPORTS; i++) begin
                if (int'(addr) == A_PHYTAB + i / 6)
                    phy_tab[i] <= wdata[(i % 6) * 5 +: 5];
                if (int'(addr) == BS_BASE + i / 16)
                    bus_tab[i] <= wdata[(i % 16) * 2 +: BW];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (int'(addr) == A_PHYTAB + i / 6)
                rd_data[(i % 6) * 5 +: 5] = phy_tab[i];
            if (int'(addr) == BS_BASE + i / 16)
                rd_data[(i % 16) * 2 +: BW] = bus_tab[i];
        end
    end

    assign phy = (int'(port) < NPORTS) ? phy_tab[port] : '0;
    assign bus = (int'(port) < NPORTS) ? bus_tab[port] : '0;

endmodule

// File: rtl/mdix_engine.sv
module mdix_engine
    import mdix_pkg::*;
#(
    parameter int NPORTS   = 28,
    parameter int NBUS     = 4,
    parameter int DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NBUS-1:0]   mdc,
    output logic [NBUS-1:0]   mdio_o,
    output logic [NBUS-1:0]   mdio_oe,
    input  logic [NBUS-1:0]   mdio_i
);
    localparam int BW = (NBUS > 2) ? $clog2(NBUS) : 1;

    // software-visible state
    cmd_t            cmd_f;
    logic            busy;
    logic            cmd_fail;
    logic [15:0]     data_hi;
    logic [15:0]     data_lo;
    logic [4:0]      mmd_dev;
    logic [15:0]     mmd_reg;
    logic [31:0]     wmask;
    logic [NBUS-1:0] gsel;

    // values latched at acceptance
    logic            act_wr;
    logic            act_c45;
    logic [4:0]      act_rn;
    logic [31:0]     act_mask;
    logic [15:0]     act_hi;
    logic [4:0]      act_dev;
    logic [15:0]     act_mreg;
    logic [4:0]      phy_l;
    logic [BW-1:0]   sel;
    seq_e            state;

    logic [PORT_IDX_W-1:0] lk_port;
    logic [4:0]            lk_phy;
    logic [BW-1:0]         lk_bus;
    logic [31:0]           tab_rd;
    logic                  port_bad;
    logic                  mode_bad;
    logic [15:0]           wdat;
    logic [1:0]            op_xfer;
    logic                  f_start;
    logic [31:0]           f_word;
    logic                  f_drive;
    logic                  f_active;
    logic                  f_mdc;
    logic                  f_mdo;
    logic                  f_mdoe;
    logic                  f_mdi;
    logic [15:0]           f_rdata;
    logic                  f_done;
    logic                  wr_sel;

    assign wr_sel = reg_we && !(int'(reg_addr) == A_CMD && busy);

    mdix_portmap #(.NPORTS(NPORTS), .NBUS(NBUS)) u_map (
        .clk(clk), .rst(rst), .we(wr_sel), .addr(reg_addr), .wdata(reg_wdata),
        .port(lk_port), .phy(lk_phy), .bus(lk_bus), .rd_data(tab_rd)
    );

    mdix_frame #(.DIV_HALF(DIV_HALF)) u_frame (
        .clk(clk), .rst(rst), .start(f_start), .frame(f_word), .drive_all(f_drive),
        .mdi(f_mdi), .active(f_active), .mdc_lvl(f_mdc), .mdo(f_mdo), .mdoe(f_mdoe),
        .rdata(f_rdata), .done(f_done)
    );

    mdix_busmux #(.NBUS(NBUS)) u_mux (
        .sel(sel), .mdc_lvl(f_mdc), .mdo(f_mdo), .mdoe(f_mdoe), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdi(f_mdi)
    );

    // port resolution and frame selection
    always_comb begin
        lk_port  = act_wr ? low_index(act_mask) : act_hi[PORT_IDX_W-1:0];
        port_bad = act_wr ? (popcount32(act_mask) != 1 || int'(low_index(act_mask)) >= NPORTS)
                          : (int'(act_hi) >= NPORTS);
        mode_bad = (act_c45 != gsel[lk_bus]);
        wdat     = act_wr ? act_hi : 16'hFFFF;
        op_xfer  = act_wr ? OP_WR : (act_c45 ? OP_RD45 : OP_RD22);
        f_start  = 1'b0;
        f_word   = '0;
        f_drive  = 1'b0;
        case (state)
            SQ_RESOLVE: begin
                if (!port_bad && !mode_bad) begin
                    f_start = 1'b1;
                    if (act_c45) begin
                        f_word  = pack_frame(ST_C45, OP_ADDR, lk_phy, act_dev, act_mreg);
                        f_drive = 1'b1;
                    end else begin
                        f_word  = pack_frame(ST_C22, op_xfer, lk_phy, act_rn, wdat);
                        f_drive = act_wr;
                    end
                end
            end
            SQ_ADDR: begin
                if (f_done) begin
                    f_start = 1'b1;
                    f_word  = pack_frame(ST_C45, op_xfer, phy_l, act_dev, wdat);
                    f_drive = act_wr;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_f    <= '0;
            busy     <= 1'b0;
            cmd_fail <= 1'b0;
            data_hi  <= '0;
            data_lo  <= '0;
            mmd_dev  <= '0;
            mmd_reg  <= '0;
            wmask    <= '0;
            gsel     <= '0;
            act_wr   <= 1'b0;
            act_c45  <= 1'b0;
            act_rn   <= '0;
            act_mask <= '0;
            act_hi   <= '0;
            act_dev  <= '0;
            act_mreg <= '0;
            phy_l    <= '0;
            sel      <= '0;
            state    <= SQ_IDLE;
        end else begin
            if (reg_we) begin
                case (int'(reg_addr))
                    A_DATA:  {data_hi, data_lo} <= reg_wdata;
                    A_MMD:   {mmd_dev, mmd_reg} <= reg_wdata[20:0];
                    A_WMASK: wmask <= reg_wdata;
                    A_GSEL:  gsel  <= reg_wdata[GSEL_LSB +: NBUS];
                    default: ;
                endcase
            end
            case (state)
                SQ_IDLE: begin
                    if (reg_we && int'(reg_addr) == A_CMD) begin
                        cmd_f <= cmd_t'(reg_wdata[24:1]);
                        if (reg_wdata[0]) begin
                            busy     <= 1'b1;
                            cmd_fail <= 1'b0;
                            act_wr   <= reg_wdata[2];
                            act_c45  <= reg_wdata[1];
                            act_rn   <= reg_wdata[24:20];
                            act_mask <= wmask;
                            act_hi   <= data_hi;
                            act_dev  <= mmd_dev;
                            act_mreg <= mmd_reg;
                            state    <= SQ_RESOLVE;
                        end
                    end
                end
                SQ_RESOLVE: begin
                    if (port_bad || mode_bad) begin
                        busy     <= 1'b0;
                        cmd_fail <= 1'b1;
                        state    <= SQ_IDLE;
                    end else begin
                        sel   <= lk_bus;
                        phy_l <= lk_phy;
                        state <= act_c45 ? SQ_ADDR : SQ_DATA;
                    end
                end
                SQ_ADDR: begin
                    if (f_done) state <= SQ_DATA;
                end
                SQ_DATA: begin
                    if (f_done) begin
                        if (!act_wr) data_lo <= f_rdata;
                        busy  <= 1'b0;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        case (int'(reg_addr))
            A_CMD:   reg_rdata = {6'b0, cmd_fail, cmd_f, busy};
            A_DATA:  reg_rdata = {data_hi, data_lo};
            A_MMD:   reg_rdata = {11'b0, mmd_dev, mmd_reg};
            A_WMASK: reg_rdata = wmask;
            A_GSEL: begin
                reg_rdata = '0;
                reg_rdata[GSEL_LSB +: NBUS] = gsel;
            end
            default: reg_rdata = tab_rd;
        endcase
    end

endmodule

// File: rtl/mdix_checker.sv
module mdix_checker #(
    parameter int NBUS = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            fail_flag,
    input logic [NBUS-1:0] mdc,
    input logic [NBUS-1:0] mdio_o,
    input logic [NBUS-1:0] mdio_oe
);
    // R1: no bus activity while no command is in flight
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdc == '0 && mdio_oe == '0));

    // R6: at most one bus carries a clock or drives at any time
    a_r6_single_bus: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mdc) && $onehot0(mdio_oe));

    // R10: the data line holds still while the clock stays high
    a_r10_hold_high: assert property (@(posedge clk) disable iff (rst)
        (mdc != '0 && $past(mdc) == mdc) |-> $stable(mdio_o));

    // R7 / R8 / R11: a refused command leaves the buses silent
    a_r7_fail_silent: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_flag) |-> ($past(mdc) == '0 && $past(mdio_oe) == '0));

endmodule

bind mdix_engine mdix_checker #(.NBUS(NBUS)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .fail_flag(cmd_fail),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdix_engine.sv
module sim_mdix_engine;
    localparam int NP = 28;
    localparam int NB = 4;
    localparam int DH = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [3:0]   reg_addr  = '0;
    logic         reg_we    = 1'b0;
    logic [31:0]  reg_wdata = '0;
    wire  [31:0]  reg_rdata;
    wire  [NB-1:0] mdc, mdio_o, mdio_oe;
    logic [NB-1:0] mdio_i = '0;

    mdix_engine #(.NPORTS(NP), .NBUS(NB), .DIV_HALF(DH)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [4:0] phy_m [NP];
    logic [1:0] bus_m [NP];
    logic [NB-1:0] c45_m = 4'b1100;
    int edges [NB] = '{default: 0};
    logic [NB-1:0] mdc_q = '0;
    int hi_run = 0;
    int shape_err = 0;
    bit cap_o [128];
    bit cap_oe [128];

    // edge counters and MDC shape monitor (R6, R10)
    always @(posedge clk) begin
        for (int k = 0; k < NB; k++) if (mdc[k] && !mdc_q[k]) edges[k]++;
        if (|mdc) hi_run++;
        else begin
            if (hi_run != 0 && hi_run != DH) shape_err++;
            hi_run = 0;
        end
        if ((mdc & mdc_q) != '0 && mdio_o != $past(mdio_o)) shape_err++;
        mdc_q <= mdc;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] c);
        int guard = 0;
        do begin
            rd_reg(0, c);
            guard++;
        end while (c[0] && guard < 5000);
    endtask

    function automatic logic [31:0] mkcmd(input logic [4:0] rn, input bit wr, input bit c45);
        return {7'b0, rn, 5'h1f, 12'hfff, wr, c45, 1'b1};
    endfunction

    function automatic logic [31:0] efr(input bit c45, input bit addr_ph, input bit wr,
                                         input logic [4:0] phy, input logic [4:0] f2,
                                         input logic [15:0] pl);
        logic [1:0] op;
        if (addr_ph) op = 2'b00;
        else if (wr) op = 2'b01;
        else op = c45 ? 2'b11 : 2'b10;
        return {(c45 ? 2'b00 : 2'b01), op, phy, f2, 2'b10, pl};
    endfunction

    // bench PHY: records bits at each MDC rise, answers the last frame's data slots
    task automatic collect(input int b, input int nf, input logic [15:0] rv);
        int total = nf * 64;
        int n = 0;
        bit prev = 0;
        while (n < total) begin
            @(negedge clk);
            if (mdc[b] && !prev) begin
                cap_o[n]  = mdio_o[b];
                cap_oe[n] = mdio_oe[b];
                if (n >= total - 16) mdio_i[b] = rv[total - 1 - n];
                else mdio_i[b] = 1'b0;
                n++;
            end
            prev = mdc[b];
        end
        mdio_i[b] = 1'b0;
    endtask

    task automatic chk_frame(input int f, input logic [31:0] fw, input bit drive_all,
                             input string tag);
        bit pre_ok = 1;
        bit oe_ok = 1;
        logic [31:0] got = '0;
        logic [31:0] m = drive_all ? 32'hFFFF_FFFF : 32'hFFFC_0000;
        for (int n = 0; n < 64; n++) begin
            if (cap_oe[f*64+n] != (drive_all || n < 46)) oe_ok = 0;
            if (n < 32 && !cap_o[f*64+n]) pre_ok = 0;
            if (n >= 32) got[63-n] = cap_o[f*64+n];
        end
        chk(pre_ok && oe_ok && ((got & m) == (fw & m)), tag, "frame bits", got & m, fw & m);
    endtask

    task automatic do_access(input int p, input bit wr, input bit c45, input logic [4:0] rn,
                             input logic [4:0] dv, input logic [15:0] mr,
                             input logic [15:0] val, input string tag);
        int b = int'(bus_m[p]);
        logic [4:0] ph = phy_m[p];
        logic [31:0] c;
        int e0 [NB];
        bit quiet = 1;
        if (wr) begin
            wr_reg(3, 32'd1 << p);
            wr_reg(1, {val, 16'h0});
        end else begin
            wr_reg(1, {16'(p), 16'h0});
        end
        if (c45) wr_reg(2, {11'h0, dv, mr});
        e0 = edges;
        wr_reg(0, mkcmd(rn, wr, c45));
        collect(b, c45 ? 2 : 1, val);
        wait_idle(c);
        // R2 / R9: start cleared, fields kept, fail low
        chk(c == (mkcmd(rn, wr, c45) & 32'hFFFF_FFFE), tag, "command after completion",
            c, mkcmd(rn, wr, c45) & 32'hFFFF_FFFE);
        if (c45) begin
            chk_frame(0, efr(1, 1, 0, ph, dv, mr), 1, "R5");
            chk_frame(1, efr(1, 0, wr, ph, dv, val), wr, tag);
        end else begin
            chk_frame(0, efr(0, 0, wr, ph, rn, val), wr, tag);
        end
        if (!wr) begin
            rd_reg(1, c);
            chk(c == {16'(p), val}, "R4", "read data register", c, {16'(p), val});
        end
        for (int k = 0; k < NB; k++) if (k != b && edges[k] != e0[k]) quiet = 0;
        chk(quiet, "R6", "other buses idle", 32'(b), 32'(b));
    endtask

    task automatic do_fail(input logic [31:0] mask, input logic [31:0] data,
                           input logic [31:0] cmd, input string tag);
        logic [31:0] c;
        int e0 [NB];
        bit quiet = 1;
        e0 = edges;
        wr_reg(3, mask);
        wr_reg(1, data);
        wr_reg(0, cmd);
        wait_idle(c);
        chk(c[25] == 1'b1 && c[0] == 1'b0, tag, "refused command flags", c, cmd | 32'h0200_0000);
        repeat (4 * DH) @(negedge clk);
        for (int k = 0; k < NB; k++) if (edges[k] != e0[k]) quiet = 0;
        chk(quiet, tag, "no bus activity on refusal", 32'(quiet), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [31:0] c;
        logic [31:0] w;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_reg(0, c); chk(c == 0, "R1", "command reset", c, 0);
        rd_reg(1, c); chk(c == 0, "R1", "data reset", c, 0);
        rd_reg(4, c); chk(c == 0, "R1", "select reset", c, 0);
        rd_reg(5, c); chk(c == 0, "R1", "phy table reset", c, 0);
        chk(mdc == 0 && mdio_oe == 0, "R1", "bus idle", {mdc, mdio_oe}, 0);

        // table setup
        for (int i = 0; i < NP; i++) begin
            phy_m[i] = 5'($urandom_range(0, 31));
            bus_m[i] = 2'($urandom_range(0, 3));
        end
        bus_m[0] = 0; bus_m[1] = 1; bus_m[26] = 2; bus_m[27] = 3;
        for (int wd = 0; wd < 5; wd++) begin
            w = '0;
            for (int i = wd * 6; i < wd * 6 + 6 && i < NP; i++) w[(i % 6) * 5 +: 5] = phy_m[i];
            wr_reg(5 + wd, w);
        end
        for (int wd = 0; wd < 2; wd++) begin
            w = '0;
            for (int i = wd * 16; i < wd * 16 + 16 && i < NP; i++) w[(i % 16) * 2 +: 2] = bus_m[i];
            wr_reg(10 + wd, w);
        end
        wr_reg(4, {12'h0, c45_m, 16'h0});
        w = '0;
        for (int i = 24; i < NP; i++) w[(i % 6) * 5 +: 5] = phy_m[i];
        rd_reg(9, c); chk(c == w, "R6", "phy table word readback", c, w);
        w = '0;
        for (int i = 16; i < NP; i++) w[(i % 16) * 2 +: 2] = bus_m[i];
        rd_reg(11, c); chk(c == w, "R6", "bus table word readback", c, w);

        // directed accesses
        do_access(0, 1, 0, 5'd9, 5'd0, 16'h0, 16'hA5C3, "R3");
        do_access(1, 0, 0, 5'd2, 5'd0, 16'h0, 16'h1234, "R4");
        do_access(26, 1, 1, 5'd0, 5'd7, 16'hBEEF, 16'h0F0F, "R5");
        do_access(27, 0, 1, 5'd0, 5'd30, 16'h8001, 16'hC0DE, "R5");

        // refusals
        do_fail(32'h0, 32'h0, mkcmd(5'd1, 1, 0), "R7");
        do_fail(32'h0000_0003, 32'h0, mkcmd(5'd1, 1, 0), "R7");
        do_fail(32'h1000_0000, 32'h0, mkcmd(5'd1, 1, 0), "R7");
        do_fail(32'h0000_0001, 32'h0, mkcmd(5'd1, 1, 1), "R8");
        do_fail(32'h0, {16'd28, 16'h0}, mkcmd(5'd1, 0, 0), "R11");
        do_access(1, 1, 0, 5'd31, 5'd0, 16'h0, 16'h7777, "R9");

        // R2: command written while busy is ignored
        wr_reg(1, {16'd0, 16'h0});
        wr_reg(0, mkcmd(5'd3, 0, 0));
        fork
            collect(0, 1, 16'h5A5A);
            begin
                repeat (20) @(negedge clk);
                wr_reg(0, mkcmd(5'd17, 1, 1));
                rd_reg(0, c);
                chk(c == mkcmd(5'd3, 0, 0), "R2", "command while busy", c, mkcmd(5'd3, 0, 0));
            end
        join
        wait_idle(c);
        chk(c == (mkcmd(5'd3, 0, 0) & 32'hFFFF_FFFE), "R2", "self-clear", c,
            mkcmd(5'd3, 0, 0) & 32'hFFFF_FFFE);
        chk_frame(0, efr(0, 0, 0, phy_m[0], 5'd3, 16'h0), 0, "R2");
        rd_reg(1, c); chk(c == {16'd0, 16'h5A5A}, "R4", "read data after busy write", c, {16'd0, 16'h5A5A});

        // random accesses
        for (int t = 0; t < 14; t++) begin
            int p = $urandom_range(0, NP - 1);
            bit wr = 1'($urandom_range(0, 1));
            do_access(p, wr, c45_m[bus_m[p]], 5'($urandom_range(0, 31)),
                      5'($urandom_range(0, 31)), 16'($urandom), 16'($urandom), "R6");
        end

        chk(shape_err == 0, "R10", "mdc high width and mdio hold", 32'(shape_err), 0);
        summary();
    end

endmodule